// File: doc/BRIEF.md
# Dual-Slot SD Host Wrapper Register Block

This block is the small register window that fronts a pair of SD host controller slots on a 32-bit register bus. It keeps a file of plain 32-bit storage words. Two of these words come out of reset with fixed non-zero values: an identity word and a debounce setting. Each slot has a capability register and a maximum-current register. These live inside the slot, and the block exposes them as read/write aliases in its own window. Reads of an alias take the slot's live value from a sideband input. Writes to an alias go out to the slot as a one-cycle strobe with the write data. The block also merges the interrupt levels of both slots into a status bitmap and into one shared interrupt line.

A two-state access machine paces the bus. In `ST_IDLE` the block is ready. An accepted write completes there and the machine stays in `ST_IDLE`. An accepted read moves it to `ST_RESP` (transition IDLE→RESP). For that one cycle the registered read data is presented with `rd_valid` high and `req_ready` low. The machine then returns unconditionally to `ST_IDLE` (transition RESP→IDLE). The slot controllers themselves sit at window base + 0x100 × (slot + 1) and are outside this block.

Top module: `sdw_wrapper_regs`

## Requirements
- R1: After reset, word 0x00 reads 0x00030000, word 0x04 reads 0x00000005, every other storage word and the status word 0xFC read 0, and `irq_o` is 0.
- R2: Any in-range, word-aligned offset that is not an alias or the status word (for example 0x04, 0x08, 0xEC, 0xF0) stores a full-word write and returns it on later reads.
- R3: Reads of offset 0x10×(s+1) return slot s's capability input, and reads of offset 0x10×(s+1)+8 return its maximum-current input. Both are sampled in the cycle the read is accepted.
- R4: A write to an alias offset pulses exactly one strobe (capability or max-current of that slot) for one cycle, in the cycle after acceptance, with `slot_wdata_o` equal to the written data. No two strobes are ever high together.
- R5: Status word 0xFC bit s equals slot s's interrupt input as it was one clock earlier. A bit is set while the slot asserts its interrupt and clear once it deasserts.
- R6: `irq_o` is the OR of the status bits. It stays high while either slot is still pending, even after the other slot clears.
- R7: A bus write to 0xFC changes neither the status bits nor `irq_o`.
- R8: An access with a non-aligned address, an address at or above 0x100, or byte enables other than 4'b1111 reads 0, writes nothing and produces no strobe.
- R9: An accepted read (`req_valid` and `req_ready` high, `req_write` low) is followed in the next cycle by exactly one cycle of `rd_valid`, and `req_ready` is low during that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Bus access request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address within the block |
| req_be | input | 4 | Byte enables; only 4'b1111 is a valid access |
| req_wdata | input | 32 | Write data |
| req_ready | output | 1 | Block accepts a request this cycle |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 32 | Read data |
| slot_cap_i | input | NUM_SLOTS*32 | Live capability value of each slot, slot 0 in the low word |
| slot_maxcur_i | input | NUM_SLOTS*32 | Live max-current value of each slot |
| slot_irq_i | input | NUM_SLOTS | Interrupt level of each slot |
| slot_cap_we_o | output | NUM_SLOTS | Capability write strobe per slot |
| slot_maxcur_we_o | output | NUM_SLOTS | Max-current write strobe per slot |
| slot_wdata_o | output | 32 | Data carried by the strobes |
| irq_o | output | 1 | Shared interrupt |

## Verification
The bench builds the block with its defaults: two slots, a 64-word window and a 12-bit address. Because the address is wider than the window, accesses at 0x100 and 0x104 can be issued, so the out-of-range rule can be exercised beside the misaligned and partial-byte-enable cases. Two slots make it possible to overlap interrupts and check that one slot clearing leaves the shared line high. A behavioural slot model takes the strobes and feeds the live values back, so the readback of an alias shows both the strobe and the sampling of the read path.

// File: rtl/sdw_pkg.sv
package sdw_pkg;
    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_RESP = 1'b1
    } bus_state_e;

    localparam logic [31:0] IDENT_RESET    = 32'h0003_0000;
    localparam logic [31:0] DEBOUNCE_RESET = 32'h0000_0005;
endpackage

// File: rtl/sdw_bus_fsm.sv
module sdw_bus_fsm
    import sdw_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_valid,
    input  logic req_write,
    output logic req_ready,
    output logic rd_valid,
    output logic accept_rd,
    output logic accept_wr
);
    bus_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d   = state_q;
        req_ready = 1'b0;
        rd_valid  = 1'b0;
        accept_rd = 1'b0;
        accept_wr = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                req_ready = 1'b1;
                accept_rd = req_valid && !req_write;
                accept_wr = req_valid && req_write;
                if (req_valid && !req_write) state_d = ST_RESP;
            end
            ST_RESP: begin
                rd_valid = 1'b1;
                state_d  = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    assert_resp_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid);
endmodule

// File: rtl/sdw_decode.sv
module sdw_decode #(
    parameter int NUM_SLOTS = 2,
    parameter int NUM_WORDS = 64,
    parameter int ADDR_W    = 12
) (
    input  logic [ADDR_W-1:0]              addr,
    input  logic [3:0]                     be,
    output logic                           ok,
    output logic [$clog2(NUM_WORDS)-1:0]   word_idx,
    output logic [NUM_SLOTS-1:0]           cap_hit,
    output logic [NUM_SLOTS-1:0]           maxcur_hit,
    output logic                           stat_hit
);
    localparam int IDX_W      = $clog2(NUM_WORDS);
    localparam int WIN_BYTES  = NUM_WORDS * 4;
    localparam int STAT_BYTE  = WIN_BYTES - 4;

    logic in_range;
    assign in_range = ({1'b0, addr} < (ADDR_W+1)'(WIN_BYTES));
    assign ok       = in_range && (addr[1:0] == 2'b00) && (be == 4'hF);
    assign word_idx = addr[IDX_W+1:2];
    assign stat_hit = ok && (addr == ADDR_W'(STAT_BYTE));

    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_alias
        assign cap_hit[s]    = ok && (addr == ADDR_W'(16 * (s + 1)));
        assign maxcur_hit[s] = ok && (addr == ADDR_W'(16 * (s + 1) + 8));
    end
endmodule

// File: rtl/sdw_store.sv
module sdw_store
    import sdw_pkg::*;
#(
    parameter int NUM_WORDS = 64
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         we,
    input  logic [$clog2(NUM_WORDS)-1:0] idx,
    input  logic [31:0]                  wdata,
    output logic [31:0]                  rdata
);
    logic [31:0] mem_q [NUM_WORDS];

    for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
        localparam logic [31:0] RST = (w == 0) ? IDENT_RESET :
                                      (w == 1) ? DEBOUNCE_RESET : 32'h0;
        always_ff @(posedge clk) begin
            if (!rst_n)
                mem_q[w] <= RST;
            else if (we && (idx == ($clog2(NUM_WORDS))'(w)))
                mem_q[w] <= wdata;
        end
    end

    assign rdata = mem_q[idx];
endmodule

// File: rtl/sdw_irq_merge.sv
module sdw_irq_merge #(
    parameter int NUM_SLOTS = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_SLOTS-1:0] slot_irq,
    output logic [NUM_SLOTS-1:0] stat,
    output logic                 irq
);
    always_ff @(posedge clk) begin
        if (!rst_n) stat <= '0;
        else        stat <= slot_irq;
    end

    assign irq = |stat;
endmodule

// File: rtl/sdw_wrapper_regs.sv
module sdw_wrapper_regs #(
    parameter int NUM_SLOTS = 2,
    parameter int NUM_WORDS = 64,
    parameter int ADDR_W    = 12
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      req_valid,
    input  logic                      req_write,
    input  logic [ADDR_W-1:0]         req_addr,
    input  logic [3:0]                req_be,
    input  logic [31:0]               req_wdata,
    output logic                      req_ready,
    output logic                      rd_valid,
    output logic [31:0]               rd_data,
    input  logic [NUM_SLOTS*32-1:0]   slot_cap_i,
    input  logic [NUM_SLOTS*32-1:0]   slot_maxcur_i,
    input  logic [NUM_SLOTS-1:0]      slot_irq_i,
    output logic [NUM_SLOTS-1:0]      slot_cap_we_o,
    output logic [NUM_SLOTS-1:0]      slot_maxcur_we_o,
    output logic [31:0]               slot_wdata_o,
    output logic                      irq_o
);
    localparam int IDX_W = $clog2(NUM_WORDS);

    logic                 accept_rd, accept_wr, ok, stat_hit;
    logic [IDX_W-1:0]     word_idx;
    logic [NUM_SLOTS-1:0] cap_hit, maxcur_hit, stat;
    logic [31:0]          store_rdata, rmux;
    logic                 alias_hit;

    sdw_bus_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_ready(req_ready), .rd_valid(rd_valid),
        .accept_rd(accept_rd), .accept_wr(accept_wr)
    );

    sdw_decode #(.NUM_SLOTS(NUM_SLOTS), .NUM_WORDS(NUM_WORDS), .ADDR_W(ADDR_W)) u_dec (
        .addr(req_addr), .be(req_be), .ok(ok), .word_idx(word_idx),
        .cap_hit(cap_hit), .maxcur_hit(maxcur_hit), .stat_hit(stat_hit)
    );

    assign alias_hit = (|cap_hit) || (|maxcur_hit);

    sdw_store #(.NUM_WORDS(NUM_WORDS)) u_store (
        .clk(clk), .rst_n(rst_n),
        .we(accept_wr && ok && !stat_hit && !alias_hit),
        .idx(word_idx), .wdata(req_wdata), .rdata(store_rdata)
    );

    sdw_irq_merge #(.NUM_SLOTS(NUM_SLOTS)) u_irq (
        .clk(clk), .rst_n(rst_n), .slot_irq(slot_irq_i), .stat(stat), .irq(irq_o)
    );

    always_comb begin
        rmux = 32'h0;
        if (ok) begin
            if (stat_hit) rmux = 32'(stat);
            else          rmux = store_rdata;
            for (int s = 0; s < NUM_SLOTS; s++) begin
                if (cap_hit[s])    rmux = slot_cap_i[s*32 +: 32];
                if (maxcur_hit[s]) rmux = slot_maxcur_i[s*32 +: 32];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data          <= 32'h0;
            slot_cap_we_o    <= '0;
            slot_maxcur_we_o <= '0;
            slot_wdata_o     <= 32'h0;
        end else begin
            if (accept_rd) rd_data <= rmux;
            slot_cap_we_o    <= (accept_wr && ok) ? cap_hit    : '0;
            slot_maxcur_we_o <= (accept_wr && ok) ? maxcur_hit : '0;
            if (accept_wr) slot_wdata_o <= req_wdata;
        end
    end

    assert_strobe_onehot_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({slot_cap_we_o, slot_maxcur_we_o}));

    assert_strobe_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (|{slot_cap_we_o, slot_maxcur_we_o}) |-> $past(req_valid && req_write && req_ready));

    assert_read_resp_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write && req_ready) |=> (rd_valid && !req_ready));

    assert_irq_pending_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (|slot_irq_i) |=> irq_o);

    assert_irq_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_irq_i == '0) |=> !irq_o);
endmodule

// File: tb/sdw_wrapper_regs_tb_top.sv
`timescale 1ns/1ps
module sdw_wrapper_regs_tb_top;
    localparam int NS = 2;
    localparam int AW = 12;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic            req_valid = 1'b0, req_write = 1'b0;
    logic [AW-1:0]   req_addr = '0;
    logic [3:0]      req_be = 4'hF;
    logic [31:0]     req_wdata = '0;
    logic            req_ready, rd_valid, irq_o;
    logic [31:0]     rd_data, slot_wdata_o;
    logic [NS-1:0]   slot_irq_i = '0, slot_cap_we_o, slot_maxcur_we_o;
    logic [31:0]     m_cap [NS];
    logic [31:0]     m_max [NS];

    sdw_wrapper_regs dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_be(req_be), .req_wdata(req_wdata),
        .req_ready(req_ready), .rd_valid(rd_valid), .rd_data(rd_data),
        .slot_cap_i({m_cap[1], m_cap[0]}), .slot_maxcur_i({m_max[1], m_max[0]}),
        .slot_irq_i(slot_irq_i), .slot_cap_we_o(slot_cap_we_o),
        .slot_maxcur_we_o(slot_maxcur_we_o), .slot_wdata_o(slot_wdata_o),
        .irq_o(irq_o)
    );

    // behavioural slot model: holds capability/max-current, takes strobes
    always @(posedge clk) begin
        for (int s = 0; s < NS; s++) begin
            if (!rst_n) begin
                m_cap[s] <= 32'h01E8_0080;
                m_max[s] <= 32'h40 << s;
            end else begin
                if (slot_cap_we_o[s]) m_cap[s] <= slot_wdata_o;
                if (slot_maxcur_we_o[s]) m_max[s] <= slot_wdata_o;
            end
        end
    end

    int n_cmp = 0, n_bad = 0;
    bit done = 0;
    logic [31:0] exp_q[$];
    string       tag_q[$];

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // monitor: pops expected read data as responses appear
    always @(negedge clk) begin
        if (rst_n && rd_valid) begin
            if (exp_q.size() == 0) check("R9 unexpected response", 32'h1, 32'h0);
            else check(tag_q.pop_front(), rd_data, exp_q.pop_front());
        end
    end

    task automatic bus_read(logic [AW-1:0] a, logic [31:0] exp, string tag, logic [3:0] be = 4'hF);
        @(negedge clk);
        req_valid = 1; req_write = 0; req_addr = a; req_be = be;
        exp_q.push_back(exp); tag_q.push_back(tag);
        @(negedge clk);
        req_valid = 0; req_be = 4'hF;
        check("R9 ready low in response", {31'h0, req_ready}, 32'h0);
        check("R9 rd_valid high", {31'h0, rd_valid}, 32'h1);
        @(negedge clk);
        check("R9 rd_valid single", {31'h0, rd_valid}, 32'h0);
    endtask

    task automatic bus_write(logic [AW-1:0] a, logic [31:0] d, logic [3:0] be = 4'hF);
        @(negedge clk);
        req_valid = 1; req_write = 1; req_addr = a; req_wdata = d; req_be = be;
        @(negedge clk);
        req_valid = 0; req_write = 0; req_be = 4'hF;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1 reset values
        check("R1 irq_o after reset", {31'h0, irq_o}, 32'h0);
        bus_read(12'h000, 32'h0003_0000, "R1 ident word");
        bus_read(12'h004, 32'h0000_0005, "R1 debounce word");
        bus_read(12'h008, 32'h0, "R1 plain word");
        bus_read(12'h0F0, 32'h0, "R1 word F0");
        bus_read(12'h0FC, 32'h0, "R1 status word");
        // R2 plain storage
        bus_write(12'h008, 32'hA5A5_5A5A);
        bus_write(12'h0EC, 32'h0000_0001);
        bus_write(12'h0F0, 32'hDEAD_BEEF);
        bus_write(12'h004, 32'h0000_0123);
        bus_read(12'h008, 32'hA5A5_5A5A, "R2 word 08");
        bus_read(12'h0EC, 32'h0000_0001, "R2 word EC");
        bus_read(12'h0F0, 32'hDEAD_BEEF, "R2 word F0");
        bus_read(12'h004, 32'h0000_0123, "R2 debounce overwrite");
        // R3 alias reads
        bus_read(12'h010, 32'h01E8_0080, "R3 slot0 cap");
        bus_read(12'h018, 32'h0000_0040, "R3 slot0 maxcur");
        bus_read(12'h020, 32'h01E8_0080, "R3 slot1 cap");
        bus_read(12'h028, 32'h0000_0080, "R3 slot1 maxcur");
        // R4 alias write strobe
        @(negedge clk);
        req_valid = 1; req_write = 1; req_addr = 12'h020; req_wdata = 32'h1234_5678;
        @(negedge clk);
        req_valid = 0; req_write = 0;
        check("R4 cap strobe slot1", {30'h0, slot_cap_we_o}, 32'h2);
        check("R4 maxcur strobe idle", {30'h0, slot_maxcur_we_o}, 32'h0);
        check("R4 strobe data", slot_wdata_o, 32'h1234_5678);
        @(negedge clk);
        check("R4 strobe one cycle", {30'h0, slot_cap_we_o}, 32'h0);
        bus_read(12'h020, 32'h1234_5678, "R3 slot1 cap live value");
        bus_write(12'h018, 32'h0000_00C8);
        bus_read(12'h018, 32'h0000_00C8, "R4 slot0 maxcur written");
        bus_read(12'h010, 32'h01E8_0080, "R4 slot0 cap untouched");
        // R5 / R6 interrupts
        @(negedge clk); slot_irq_i = 2'b01;
        @(negedge clk);
        check("R6 irq_o slot0", {31'h0, irq_o}, 32'h1);
        bus_read(12'h0FC, 32'h1, "R5 status slot0");
        slot_irq_i = 2'b11;
        bus_read(12'h0FC, 32'h3, "R5 status both");
        @(negedge clk); slot_irq_i = 2'b10;
        @(negedge clk);
        check("R6 irq_o held by slot1", {31'h0, irq_o}, 32'h1);
        bus_read(12'h0FC, 32'h2, "R5 status slot1 only");
        // R7 write to status ignored
        bus_write(12'h0FC, 32'h0);
        check("R7 irq_o after status write", {31'h0, irq_o}, 32'h1);
        bus_read(12'h0FC, 32'h2, "R7 status kept");
        slot_irq_i = 2'b00;
        @(negedge clk); @(negedge clk);
        check("R6 irq_o clear", {31'h0, irq_o}, 32'h0);
        bus_write(12'h0FC, 32'hFFFF_FFFF);
        check("R7 irq_o stays low", {31'h0, irq_o}, 32'h0);
        bus_read(12'h0FC, 32'h0, "R7 status stays zero");
        // R8 invalid accesses
        bus_read(12'h009, 32'h0, "R8 misaligned read");
        bus_read(12'h100, 32'h0, "R8 out-of-range read");
        bus_read(12'h008, 32'h0, "R8 partial be read", 4'h3);
        bus_write(12'h009, 32'h1111_1111);
        bus_write(12'h104, 32'h2222_2222);
        bus_write(12'h008, 32'h3333_3333, 4'h3);
        @(negedge clk);
        req_valid = 1; req_write = 1; req_addr = 12'h011; req_wdata = 32'h4444_4444;
        @(negedge clk);
        req_valid = 0; req_write = 0;
        check("R8 no strobe on misaligned alias", {28'h0, slot_cap_we_o, slot_maxcur_we_o}, 32'h0);
        bus_read(12'h008, 32'hA5A5_5A5A, "R8 word 08 unchanged");
        bus_read(12'h004, 32'h0000_0123, "R8 word 04 unchanged");
        bus_read(12'h010, 32'h01E8_0080, "R8 slot0 cap unchanged");
        repeat (3) @(negedge clk);
        check("R9 no pending responses", 32'(exp_q.size()), 32'h0);
        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule